// File: doc/BRIEF.md
# Power-On Strap Latch with Test-Mode Clock Divider

This block is the digital configuration core of a multi-output clock generator. Four shared pads carry configuration straps at power-up: three frequency-select bits and one bus-source select. Once the reset input is released, a power-on window runs for a parameterized number of reference cycles. The straps are captured on the last cycle of that window and then held. One cycle after the capture, the output enable rises and the pad cells switch the shared pins to clock-driving outputs.

The latched code sets one of three modes. Normal mode forwards clocks from external PLL-domain inputs. Production test mode derives every output from the reference by fixed integer division. Tristate mode disables and silences every output. The frequency-select bits are passed on to the PLL.

Two active-low stop requests halt the two SDRAM output groups without glitches. Each request is synchronized into the SDRAM source clock domain. The gate enable changes only while that clock is low, so a stopped output parks low and never emits a short pulse.

Top module: `clkgen_cfg_core`

## Requirements
- R1: `strap_in` is captured on the final cycle of a window of POR_CYCLES reference cycles after `rst_n` goes high, with bit layout {bus-select, fsel[2:0]}. It never changes afterwards until the next reset, and `pll_fsel` shows the captured fsel[2:0].
- R2: `out_en` is 0 while `rst_n` is low and throughout the window. It rises one reference cycle after the capture unless the tristate code was captured.
- R3: Test mode (fsel = 3'b110): `cpu_clk`, both SDRAM outputs and `usb48_clk` run at ref/2, and `clk24` runs at ref/4.
- R4: Test mode bus clock: with bus-select 1 it runs at ref/4. With bus-select 0 it runs at ref/3 with a high time of 1.5 reference periods.
- R5: Tristate mode (fsel = 3'b111): `out_en` stays 0 and every clock output is held at 0.
- R6: `ref_out` and `ioapic_clk` equal the reference clock in normal and test modes.
- R7: Normal mode (any other fsel): `cpu_clk` and both SDRAM outputs follow `pll_cpu_clk`, `usb48_clk` follows `pll_48_clk`, and `clk24` is `pll_48_clk`/2.
- R8: Normal mode bus clock: with bus-select 1 it is `pll_cpu_clk`/2. With bus-select 0 it follows `pll_bus_clk`.
- R9: `sd_stop_a_n` = 0 halts `sdram_a_clk` low, and `sd_stop_b_n` = 0 halts `sdram_b_clk` low. Each stop leaves the other group running, and each group resumes when its request is released.
- R10: Stopping and restarting an SDRAM group never produces a high pulse shorter than a half period of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (crystal or tester) |
| rst_n | input | 1 | Power-on reset, active low, synchronous to ref_clk |
| strap_in | input | 4 | Pad input values of the shared pins {bus-select, fsel[2:0]} |
| pll_cpu_clk | input | 1 | PLL CPU-rate clock used in normal mode |
| pll_bus_clk | input | 1 | Asynchronous bus clock used in normal mode |
| pll_48_clk | input | 1 | PLL 48 MHz clock used in normal mode |
| sd_stop_a_n | input | 1 | Stop request for SDRAM group A, active low, asynchronous |
| sd_stop_b_n | input | 1 | Stop request for SDRAM group B, active low, asynchronous |
| out_en | output | 1 | Output drive enable for all clock pads, including the shared ones |
| pll_fsel | output | 3 | Latched frequency-select code for the PLL |
| cpu_clk | output | 1 | CPU clock |
| sdram_a_clk | output | 1 | Gated SDRAM clock, group A |
| sdram_b_clk | output | 1 | Gated SDRAM clock, group B |
| bus_clk | output | 1 | Bus clock |
| usb48_clk | output | 1 | 48 MHz clock |
| clk24 | output | 1 | 24 MHz clock |
| ref_out | output | 1 | Buffered reference |
| ioapic_clk | output | 1 | Reference copy for the interrupt controller |

## Verification
The assertions assume several things about the inputs. The PLL clocks keep running while `rst_n` is low, so the flops in those domains reach their reset values. `rst_n` stays low for several reference cycles. The straps are steady at the capture edge. The bench follows these rules: it starts every PLL clock at time zero, holds reset for four cycles, and changes `strap_in` only on falling reference edges well clear of the capture edge. It toggles the stop requests at arbitrary times that are unrelated to any clock, so the synchronizers and the low-phase gate switching see truly asynchronous requests.

// File: rtl/clkgen_cfg_pkg.sv
// Shared types for the clock generator configuration core.
// Assumes strap layout {bus-select, fsel[2:0]}.
package clkgen_cfg_pkg;

    localparam int STRAP_W = 4;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_TEST = 2'd1,
        MODE_TRI  = 2'd2
    } cg_mode_e;

    typedef struct packed {
        logic       bsel;
        logic [2:0] fsel;
    } strap_t;

    // Maps a latched strap word onto its operating mode.
    function automatic cg_mode_e decode_mode(strap_t s);
        if (s.fsel == 3'b111) return MODE_TRI;
        if (s.fsel == 3'b110) return MODE_TEST;
        return MODE_NORM;
    endfunction

endpackage

// File: rtl/clkgen_por_strap.sv
// Power-on window counter and strap capture register.
// Counts POR_CYCLES reference cycles after rst_n rises, captures the straps
// on the last one, then enables the outputs one cycle later unless tristate.
// Assumes strap_in is steady around the capture edge.
module clkgen_por_strap
    import clkgen_cfg_pkg::*;
#(
    parameter int POR_CYCLES = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    output strap_t             cfg,
    output cg_mode_e           mode,
    output logic               done,
    output logic               oe
);
    localparam int CW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Window counter and one-shot strap capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
            cfg  <= '0;
        end else if (!done) begin
            if (cnt == LAST) begin
                done <= 1'b1;
                cfg  <= strap_t'(strap_in);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign mode = decode_mode(cfg);

    // Output enable, one cycle behind the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) oe <= 1'b0;
        else        oe <= done && (mode != MODE_TRI);
    end

    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(cfg));

    p_capture_at_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cnt) == LAST));

    p_oe_in_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> !oe);

endmodule

// File: rtl/clkgen_test_div.sv
// Reference dividers for production test mode: /2, /4 and a 50% duty /3.
// The /3 output uses a falling-edge stage to stretch its high time to 1.5
// reference periods. Assumes ref_clk runs during reset.
module clkgen_test_div (
    input  logic clk,
    input  logic rst_n,
    output logic div2,
    output logic div4,
    output logic div3
);
    logic [1:0] cnt4;
    logic [1:0] cnt3;
    logic       pos_q;
    logic       neg_q;

    // Power-of-two dividers from a free-running counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt4 <= '0;
        else        cnt4 <= cnt4 + 1'b1;
    end

    assign div2 = cnt4[0];
    assign div4 = cnt4[1];

    // Modulo-3 counter and its rising-edge phase flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt3  <= '0;
            pos_q <= 1'b0;
        end else begin
            cnt3  <= (cnt3 == 2'd2) ? 2'd0 : cnt3 + 1'b1;
            pos_q <= (cnt3 == 2'd2);
        end
    end

    // Falling-edge copy that extends the high phase by half a period.
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_q;
    end

    assign div3 = pos_q | neg_q;

    p_div3_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt3 != 2'd3);

    p_div3_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q |=> !pos_q);

endmodule

// File: rtl/clkgen_stop_gate.sv
// Glitch-free stop gate for one SDRAM output group.
// The asynchronous stop request is synchronized on the rising edge of the
// source clock, and the gate enable is loaded on its falling edge, so the
// enable only moves while the source is low. Assumes the source runs in reset.
module clkgen_stop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic stop_n,
    output logic gated
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_q;

    // Request synchronizer in the source clock domain.
    always_ff @(posedge src_clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], stop_n};
    end

    // Enable update during the low phase of the source.
    always_ff @(negedge src_clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= sync_q[SYNC_STAGES-1];
    end

    assign gated = src_clk & en_q;

    p_gate_rise_sync_r9: assert property (@(posedge src_clk) disable iff (!rst_n)
        $rose(en_q) |-> sync_q[SYNC_STAGES-1]);

    p_gate_fall_sync_r10: assert property (@(posedge src_clk) disable iff (!rst_n)
        $fell(en_q) |-> !sync_q[SYNC_STAGES-1]);

endmodule

// File: rtl/clkgen_cfg_core.sv
// Configuration and test-mode core of a multi-output clock generator.
// Captures straps at the end of the power-on window, selects normal, test or
// tristate sourcing for every output and gates the two SDRAM groups.
// Assumes the PLL inputs run during reset and straps are quiet at capture.
module clkgen_cfg_core
    import clkgen_cfg_pkg::*;
#(
    parameter int POR_CYCLES  = 4096,
    parameter int SYNC_STAGES = 2,
    parameter int SD_GROUPS   = 2
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               pll_cpu_clk,
    input  logic               pll_bus_clk,
    input  logic               pll_48_clk,
    input  logic               sd_stop_a_n,
    input  logic               sd_stop_b_n,
    output logic               out_en,
    output logic [2:0]         pll_fsel,
    output logic               cpu_clk,
    output logic               sdram_a_clk,
    output logic               sdram_b_clk,
    output logic               bus_clk,
    output logic               usb48_clk,
    output logic               clk24,
    output logic               ref_out,
    output logic               ioapic_clk
);
    strap_t   cfg;
    cg_mode_e mode;
    logic     por_done;
    logic     t_div2, t_div4, t_div3;
    logic     cpu_half, half48;
    logic     sd_src;
    logic [SD_GROUPS-1:0] stop_vec;
    logic [SD_GROUPS-1:0] sd_out;

    clkgen_por_strap #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .strap_in (strap_in),
        .cfg      (cfg),
        .mode     (mode),
        .done     (por_done),
        .oe       (out_en)
    );

    clkgen_test_div u_tdiv (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .div2  (t_div2),
        .div4  (t_div4),
        .div3  (t_div3)
    );

    // CPU-rate halving for the synchronous normal-mode bus clock.
    always_ff @(posedge pll_cpu_clk) begin
        if (!rst_n) cpu_half <= 1'b0;
        else        cpu_half <= ~cpu_half;
    end

    // 48 MHz halving for the normal-mode 24 MHz output.
    always_ff @(posedge pll_48_clk) begin
        if (!rst_n) half48 <= 1'b0;
        else        half48 <= ~half48;
    end

    // Per-mode source selection for every output.
    always_comb begin
        unique case (mode)
            MODE_TEST: begin
                cpu_clk    = t_div2;
                sd_src     = t_div2;
                usb48_clk  = t_div2;
                clk24      = t_div4;
                bus_clk    = cfg.bsel ? t_div4 : t_div3;
                ref_out    = ref_clk;
                ioapic_clk = ref_clk;
            end
            MODE_TRI: begin
                cpu_clk    = 1'b0;
                sd_src     = 1'b0;
                usb48_clk  = 1'b0;
                clk24      = 1'b0;
                bus_clk    = 1'b0;
                ref_out    = 1'b0;
                ioapic_clk = 1'b0;
            end
            default: begin
                cpu_clk    = pll_cpu_clk;
                sd_src     = pll_cpu_clk;
                usb48_clk  = pll_48_clk;
                clk24      = half48;
                bus_clk    = cfg.bsel ? cpu_half : pll_bus_clk;
                ref_out    = ref_clk;
                ioapic_clk = ref_clk;
            end
        endcase
    end

    assign stop_vec = {sd_stop_b_n, sd_stop_a_n};

    for (genvar g = 0; g < SD_GROUPS; g++) begin : g_sd
        clkgen_stop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .src_clk (sd_src),
            .rst_n   (rst_n),
            .stop_n  (stop_vec[g]),
            .gated   (sd_out[g])
        );
    end

    assign sdram_a_clk = sd_out[0];
    assign sdram_b_clk = sd_out[1];
    assign pll_fsel    = cfg.fsel;

    p_tristate_quiet_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mode == MODE_TRI) |-> (!out_en && !cpu_clk && !bus_clk && !ref_out
                                && !sdram_a_clk && !sdram_b_clk && !clk24));

    p_oe_needs_done_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        out_en |-> por_done);

endmodule

// File: tb/clkgen_cfg_core_tb_top.sv
`timescale 1ns/1ps
module clkgen_cfg_core_tb_top;
    localparam int  POR = 16;
    localparam real WIN = 960.0;

    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] strap_in = 4'h0;
    logic       pll_cpu_clk = 1'b0;
    logic       pll_bus_clk = 1'b0;
    logic       pll_48_clk = 1'b0;
    logic       sd_stop_a_n = 1'b1;
    logic       sd_stop_b_n = 1'b1;
    logic       out_en;
    logic [2:0] pll_fsel;
    logic       cpu_clk, sdram_a_clk, sdram_b_clk, bus_clk;
    logic       usb48_clk, clk24, ref_out, ioapic_clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int c_cpu = 0, c_sda = 0, c_sdb = 0, c_bus = 0;
    int c_usb = 0, c_c24 = 0, c_ref = 0, c_io = 0;
    int d_cpu, d_sda, d_sdb, d_bus, d_usb, d_c24, d_ref, d_io;
    real bus_rise = 0.0, bus_hi = 0.0;
    real sda_rise = 0.0, sdb_rise = 0.0;
    bit  mon_on = 0;
    int  runts = 0;

    always #4    ref_clk     = ~ref_clk;
    always #3    pll_cpu_clk = ~pll_cpu_clk;
    always #5    pll_bus_clk = ~pll_bus_clk;
    always #10   pll_48_clk  = ~pll_48_clk;

    clkgen_cfg_core #(.POR_CYCLES(POR)) dut_i (
        .ref_clk(ref_clk), .rst_n(rst_n), .strap_in(strap_in),
        .pll_cpu_clk(pll_cpu_clk), .pll_bus_clk(pll_bus_clk),
        .pll_48_clk(pll_48_clk), .sd_stop_a_n(sd_stop_a_n),
        .sd_stop_b_n(sd_stop_b_n), .out_en(out_en), .pll_fsel(pll_fsel),
        .cpu_clk(cpu_clk), .sdram_a_clk(sdram_a_clk), .sdram_b_clk(sdram_b_clk),
        .bus_clk(bus_clk), .usb48_clk(usb48_clk), .clk24(clk24),
        .ref_out(ref_out), .ioapic_clk(ioapic_clk)
    );

    always @(posedge cpu_clk)     c_cpu++;
    always @(posedge sdram_a_clk) begin c_sda++; sda_rise = $realtime; end
    always @(posedge sdram_b_clk) begin c_sdb++; sdb_rise = $realtime; end
    always @(posedge bus_clk)     begin c_bus++; bus_rise = $realtime; end
    always @(negedge bus_clk)     bus_hi = $realtime - bus_rise;
    always @(posedge usb48_clk)   c_usb++;
    always @(posedge clk24)       c_c24++;
    always @(posedge ref_out)     c_ref++;
    always @(posedge ioapic_clk)  c_io++;
    always @(negedge sdram_a_clk) if (mon_on && ($realtime - sda_rise) < 2.9) runts++;
    always @(negedge sdram_b_clk) if (mon_on && ($realtime - sdb_rise) < 2.9) runts++;

    task automatic chk(input string req, input int act, input int exp, input int tol);
        n_tests++;
        if (act < exp - tol || act > exp + tol) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure();
        int b0, b1, b2, b3, b4, b5, b6, b7;
        b0 = c_cpu; b1 = c_sda; b2 = c_sdb; b3 = c_bus;
        b4 = c_usb; b5 = c_c24; b6 = c_ref; b7 = c_io;
        #(WIN);
        d_cpu = c_cpu - b0; d_sda = c_sda - b1; d_sdb = c_sdb - b2; d_bus = c_bus - b3;
        d_usb = c_usb - b4; d_c24 = c_c24 - b5; d_ref = c_ref - b6; d_io = c_io - b7;
    endtask

    task automatic power_up(input logic [3:0] first, input logic [3:0] last);
        @(negedge ref_clk);
        rst_n = 1'b0; strap_in = first;
        repeat (4) @(negedge ref_clk);
        rst_n = 1'b1;
        repeat (4) @(negedge ref_clk);
        strap_in = last;
        repeat (POR) @(negedge ref_clk);
        strap_in = ~last;
        repeat (4) @(negedge ref_clk);
    endtask

    // R1 R2: reset state and enable timing inside the window.
    task automatic t_por_window();
        @(negedge ref_clk);
        rst_n = 1'b0; strap_in = 4'b1010;
        repeat (4) @(negedge ref_clk);
        chk("R2 out_en in reset", out_en, 0, 0);
        chk("R1 fsel reset value", pll_fsel, 0, 0);
        rst_n = 1'b1;
        repeat (POR - 2) @(negedge ref_clk);
        chk("R2 out_en inside window", out_en, 0, 0);
        chk("R1 fsel before capture", pll_fsel, 0, 0);
        repeat (6) @(negedge ref_clk);
        chk("R2 out_en after window", out_en, 1, 0);
        chk("R1 fsel captured", pll_fsel, 3'b010, 0);
    endtask

    // R1: late strap value wins, later pad activity is ignored.
    task automatic t_strap_hold();
        power_up(4'b0001, 4'b0101);
        chk("R1 last value in window latched", pll_fsel, 3'b101, 0);
        repeat (20) @(negedge ref_clk);
        chk("R1 held after pad change", pll_fsel, 3'b101, 0);
        chk("R2 enabled in normal", out_en, 1, 0);
    endtask

    // R3 R4 R6: test mode rates.
    task automatic t_test_mode(input logic bsel);
        power_up({bsel, 3'b110}, {bsel, 3'b110});
        measure();
        chk("R3 cpu ref/2", d_cpu, 60, 1);
        chk("R3 sdram a ref/2", d_sda, 60, 1);
        chk("R3 sdram b ref/2", d_sdb, 60, 1);
        chk("R3 usb48 ref/2", d_usb, 60, 1);
        chk("R3 clk24 ref/4", d_c24, 30, 1);
        chk("R6 ref in test", d_ref, 120, 1);
        chk("R6 ioapic in test", d_io, 120, 1);
        if (bsel) begin
            chk("R4 bus ref/4", d_bus, 30, 1);
        end else begin
            chk("R4 bus ref/3", d_bus, 40, 1);
            chk("R4 bus /3 high time x10ns", int'(bus_hi * 10.0), 120, 1);
        end
    endtask

    // R5: tristate code.
    task automatic t_tristate();
        power_up(4'b0111, 4'b0111);
        measure();
        chk("R5 out_en low", out_en, 0, 0);
        chk("R5 cpu silent", d_cpu, 0, 0);
        chk("R5 sdram silent", d_sda + d_sdb, 0, 0);
        chk("R5 bus usb 24 silent", d_bus + d_usb + d_c24, 0, 0);
        chk("R5 ref ioapic silent", d_ref + d_io, 0, 0);
    endtask

    // R7 R8 R6: normal mode sourcing.
    task automatic t_normal(input logic bsel);
        power_up({bsel, 3'b011}, {bsel, 3'b011});
        measure();
        chk("R7 cpu from pll", d_cpu, 160, 1);
        chk("R7 sdram a from pll", d_sda, 160, 1);
        chk("R7 usb48 from pll", d_usb, 48, 1);
        chk("R7 clk24 pll48/2", d_c24, 24, 1);
        chk("R6 ref in normal", d_ref, 120, 1);
        if (bsel) chk("R8 bus cpu/2", d_bus, 80, 1);
        else      chk("R8 bus async", d_bus, 96, 1);
    endtask

    // R9 R10: stop gating per group.
    task automatic t_stop_gate();
        power_up(4'b1000, 4'b1000);
        mon_on = 1;
        #7.3 sd_stop_a_n = 1'b0;
        #101;
        measure();
        chk("R9 group a halted", d_sda, 0, 0);
        chk("R9 group a parks low", sdram_a_clk, 0, 0);
        chk("R9 group b runs", d_sdb, 160, 1);
        #13.1 sd_stop_a_n = 1'b1;
        #4.7  sd_stop_b_n = 1'b0;
        #101;
        measure();
        chk("R9 group a resumed", d_sda, 160, 1);
        chk("R9 group b halted", d_sdb, 0, 0);
        chk("R9 group b parks low", sdram_b_clk, 0, 0);
        for (int i = 0; i < 12; i++) begin
            #(5.3 + i * 1.7) sd_stop_a_n = ~sd_stop_a_n;
            #(2.9 + i * 0.9) sd_stop_b_n = ~sd_stop_b_n;
        end
        sd_stop_a_n = 1'b1; sd_stop_b_n = 1'b1;
        #100;
        mon_on = 0;
        chk("R10 no runt pulses", runts, 0, 0);
    endtask

    initial begin
        t_por_window();
        t_strap_hold();
        t_test_mode(1'b1);
        t_test_mode(1'b0);
        t_tristate();
        t_normal(1'b1);
        t_normal(1'b0);
        t_stop_gate();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule